// File: doc/BRIEF.md
# Packet Command PIO Interface Controller

This block is the device side of an ATA-style packet interface for an optical drive. The host sends a packet command strobe. It then writes a 12-byte command packet as six 16-bit words into the data register. The controller answers with the usual handshake bits: busy, data request, and the two interrupt-reason bits, command-or-data and direction. It also drives a byte-count value and a level interrupt request.

Once the packet is in, the controller holds busy and presents the packet to the command decoder. The decoder picks one of four paths through a small command-type input:

- **No data:** the command completes at once.
- **Host-to-device PIO:** the host writes words into the buffer.
- **Device-to-host PIO:** the host reads words out of the buffer.
- **Sector streaming:** the start sector and sector count come from the packet, and the data is delivered in buffer-sized chunks of whole sectors.

The PIO buffer is a dual-port RAM. The host side walks it with a byte head. The media side fills it or inspects it through its own port.

Status reads have a side effect. A read of the main status register drops the pending interrupt. A read of the alternate status register leaves it alone.

Top module: `pkt_pio_ctrl`

## Requirements
- R1: After reset, status_o is 0x00, reason_o is 00, bcount_o is 0, irq_o is 0 and pkt_rdy_o is 0.
- R2: A cmd_pkt strobe while idle sets DRQ (status_o bit 3), clears BSY (status_o bit 7), sets reason_o to 01 (bit 1 = IO direction-to-host, bit 0 = CoD), raises irq_o and restarts the packet head at byte 0.
- R3: After the sixth data-register write of a packet, BSY=1, DRQ=0 and pkt_rdy_o=1. pkt_o bits [16k+15:16k] hold word k, so packet byte 2k is the low byte of word k.
- R4: dev_go with dev_path=0 (no data) while pkt_rdy_o is high completes the command: BSY=0, DRQ=0, reason_o=11, irq_o=1, and the controller returns to idle.
- R5: dev_go with dev_path=1 (host-to-device) loads bcount_o with dev_len and sets reason_o=00, DRQ=1, BSY=0 and irq_o=1. Each data write stores its word at buffer word head/2 and advances the head by 2. The command completes when the head reaches dev_len.
- R6: dev_go with dev_path=2 (device-to-host) loads bcount_o with dev_len and sets reason_o=10, DRQ=1, BSY=0 and irq_o=1. dat_rdata always shows buffer word head/2, and each dat_re advances the head by 2. The command completes when the head reaches dev_len.
- R7: dev_go with dev_path=3 (sector streaming) delivers chunks of min(remaining, floor(BUF_BYTES/SECT_BYTES)) sectors. For each chunk, bcount_o = sectors*SECT_BYTES and chunk_lba_o and chunk_secs_o give the chunk. When a chunk is drained and sectors remain, the next chunk starts with the head at 0, chunk_lba_o advanced by the previous chunk size and irq_o raised. When no sectors remain, the command completes.
- R8: The start sector comes from packet bytes 2,3,4. If byte 1 bit 0 is 1, it is minutes*4500 + seconds*75 + frames. Otherwise it is the 24-bit value {byte2,byte3,byte4}. The sector count is {byte8,byte9,byte10}.
- R9: stat_re clears irq_o on the next edge, and alt_re leaves irq_o unchanged. When an interrupt-raising event coincides with stat_re, irq_o ends up 1.
- R10: The following accesses leave the head, buffer, byte count and state unchanged:
  - data writes outside the packet and host-to-device phases;
  - data reads outside the two device-to-host phases.
- R11: A host-to-device or device-to-host path with dev_len=0, or sector streaming with a count of 0, completes on dev_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_pkt | input | 1 | Host issues the packet command |
| dat_we | input | 1 | Host data-register write strobe |
| dat_wdata | input | 16 | Host write word |
| dat_re | input | 1 | Host data-register read strobe |
| dat_rdata | output | 16 | Buffer word at the current head |
| stat_re | input | 1 | Host read of main status (clears interrupt) |
| alt_re | input | 1 | Host read of alternate status |
| status_o | output | 8 | Status: bit 7 BSY, bit 3 DRQ |
| reason_o | output | 2 | Interrupt reason: bit 1 IO, bit 0 CoD |
| bcount_o | output | BC_W | Byte count of the current transfer |
| irq_o | output | 1 | Interrupt request |
| pkt_rdy_o | output | 1 | Packet received, waiting for a path |
| pkt_o | output | 96 | Received packet, word k at [16k+15:16k] |
| dev_go | input | 1 | Decoder selects the path |
| dev_path | input | 2 | 0 none, 1 host-to-device, 2 device-to-host, 3 sectors |
| dev_len | input | BC_W | PIO transfer length in bytes |
| chunk_lba_o | output | 24 | First sector of the current chunk |
| chunk_secs_o | output | 24 | Sectors in the current chunk |
| med_we | input | 1 | Media-side buffer write |
| med_addr | input | AW | Media-side word address |
| med_wdata | input | 16 | Media-side write word |
| med_rdata | output | 16 | Media-side read word |

## Verification
Every handshake, byte-count and interrupt result is registered. It is due at the first rising edge after the strobe that causes it. dat_rdata and med_rdata are combinational and follow the head or address in the same cycle.

The bench drives each strobe at a falling edge and holds it for one cycle. It samples the registered outputs at the following falling edge, and reads data words before issuing the read strobe that moves the head. Chunk changes in sector streaming are checked on the falling edge right after the strobe that drains the last word of a chunk.

// File: rtl/pkt_pio_pkg.sv
package pkt_pio_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY,
    ST_RD_CMD,
    ST_DECIDE,
    ST_RD_DATA,
    ST_WR_DATA,
    ST_WR_SECT
  } state_e;

  typedef enum logic [1:0] {
    PATH_NONE    = 2'd0,
    PATH_TO_DEV  = 2'd1,
    PATH_TO_HOST = 2'd2,
    PATH_SECT    = 2'd3
  } path_e;

  // start sector from three packet bytes, time form or linear form
  function automatic logic [23:0] start_sector(input logic msf, input logic [7:0] a,
                                               input logic [7:0] b, input logic [7:0] c);
    logic [23:0] t;
    t = {16'd0, a} * 24'd4500 + {16'd0, b} * 24'd75 + {16'd0, c};
    return msf ? t : {a, b, c};
  endfunction

  // whole sectors that fit in one buffer load
  function automatic logic [23:0] chunk_secs(input logic [23:0] rem, input logic [23:0] per_buf);
    return (rem > per_buf) ? per_buf : rem;
  endfunction

endpackage

// File: rtl/pkt_pio_buf.sv
module pkt_pio_buf #(
  parameter int WORDS = 3584,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [15:0]   wd_a,
  output logic [15:0]   rd_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [15:0]   wd_b,
  output logic [15:0]   rd_b
);

  logic [15:0] mem [WORDS];

  // host port is written last so it wins an address collision
  always_ff @(posedge clk) begin
    if (we_b) mem[addr_b] <= wd_b;
    if (we_a) mem[addr_a] <= wd_a;
  end

  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];

endmodule

// File: rtl/pkt_pio_sect.sv
module pkt_pio_sect #(
  parameter int SPC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        adv,
  input  logic [23:0] start,
  input  logic [23:0] count,
  output logic [23:0] lba_o,
  output logic [23:0] secs_o,
  output logic [23:0] rem_o
);
  import pkt_pio_pkg::*;

  localparam logic [23:0] PER_BUF = 24'(SPC);

  logic [23:0] first_n, next_n;
  assign first_n = chunk_secs(count, PER_BUF);
  assign next_n  = chunk_secs(rem_o, PER_BUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lba_o  <= '0;
      secs_o <= '0;
      rem_o  <= '0;
    end else if (load) begin
      lba_o  <= start;
      secs_o <= first_n;
      rem_o  <= count - first_n;
    end else if (adv) begin
      lba_o  <= lba_o + secs_o;
      secs_o <= next_n;
      rem_o  <= rem_o - next_n;
    end
  end

  assert_chunk_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    secs_o <= PER_BUF);
  assert_lba_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load |=> lba_o == $past(lba_o) + $past(secs_o));

endmodule

// File: rtl/pkt_pio_fsm.sv
module pkt_pio_fsm
  import pkt_pio_pkg::*;
#(
  parameter int BC_W       = 16,
  parameter int AW         = 12,
  parameter int SECT_BYTES = 2352,
  parameter int SPC        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_pkt,
  input  logic            dat_we,
  input  logic [15:0]     dat_wdata,
  input  logic            dat_re,
  input  logic            stat_re,
  input  logic            dev_go,
  input  logic [1:0]      dev_path,
  input  logic [BC_W-1:0] dev_len,
  input  logic [23:0]     sect_rem,
  output logic            sect_load,
  output logic            sect_adv,
  output logic [23:0]     sect_start,
  output logic [23:0]     sect_count,
  output logic            buf_we,
  output logic [AW-1:0]   buf_addr,
  output logic            bsy,
  output logic            drq,
  output logic            cod,
  output logic            io,
  output logic            irq,
  output logic            pkt_rdy,
  output logic [BC_W-1:0] bcount,
  output logic [95:0]     pkt_flat
);

  localparam int          HW      = AW + 1;
  localparam logic [23:0] PER_BUF = 24'(SPC);

  state_e          st, st_go;
  path_e           path;
  logic [HW-1:0]   head, head_inc;
  logic [BC_W-1:0] bc_q, bc_go, bc_next;
  logic [15:0]     pkt_q [6];

  // named internal events
  logic in_sby, in_cmd, in_dec, in_rdd, in_out;
  logic ev_cmd, ev_pkt_word, ev_pkt_end, ev_go, zero_req;
  logic ev_dat_in, ev_dat_out, at_end, ev_chunk, ev_done, ev_start, irq_set;

  assign path     = path_e'(dev_path);
  assign head_inc = head + HW'(2);

  assign sect_start = start_sector(pkt_q[0][8], pkt_q[1][7:0], pkt_q[1][15:8], pkt_q[2][7:0]);
  assign sect_count = {pkt_q[4][7:0], pkt_q[4][15:8], pkt_q[5][7:0]};

  always_comb begin
    in_sby      = st == ST_STANDBY;
    in_cmd      = st == ST_RD_CMD;
    in_dec      = st == ST_DECIDE;
    in_rdd      = st == ST_RD_DATA;
    in_out      = (st == ST_WR_DATA) || (st == ST_WR_SECT);
    ev_cmd      = in_sby && cmd_pkt;
    ev_pkt_word = in_cmd && dat_we;
    ev_pkt_end  = ev_pkt_word && (head_inc == HW'(12));
    ev_go       = in_dec && dev_go;
    zero_req    = (path == PATH_NONE) ||
                  ((path == PATH_TO_DEV || path == PATH_TO_HOST) && dev_len == '0) ||
                  ((path == PATH_SECT) && sect_count == 24'd0);
    ev_dat_in   = in_rdd && dat_we;
    ev_dat_out  = in_out && dat_re;
    at_end      = BC_W'(head_inc) == bc_q;
    ev_chunk    = (st == ST_WR_SECT) && ev_dat_out && at_end && (sect_rem != 24'd0);
    ev_done     = (ev_go && zero_req) || ((ev_dat_in || ev_dat_out) && at_end && !ev_chunk);
    ev_start    = ev_go && !zero_req;
    irq_set     = ev_cmd || ev_start || ev_chunk || ev_done;

    bc_next = BC_W'(chunk_secs(sect_rem, PER_BUF) * SECT_BYTES);
    case (path)
      PATH_TO_DEV:  begin st_go = ST_RD_DATA; bc_go = dev_len; end
      PATH_TO_HOST: begin st_go = ST_WR_DATA; bc_go = dev_len; end
      PATH_SECT:    begin st_go = ST_WR_SECT;
                          bc_go = BC_W'(chunk_secs(sect_count, PER_BUF) * SECT_BYTES); end
      default:      begin st_go = ST_STANDBY; bc_go = dev_len; end
    endcase
  end

  assign sect_load = ev_go && (path == PATH_SECT);
  assign sect_adv  = ev_chunk;
  assign buf_we    = ev_dat_in;
  assign buf_addr  = head[AW:1];
  assign pkt_rdy   = in_dec;
  assign bcount    = bc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_STANDBY;
      head <= '0;
      bc_q <= '0;
      bsy  <= 1'b0;
      drq  <= 1'b0;
      cod  <= 1'b0;
      io   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (irq_set)      irq <= 1'b1;
      else if (stat_re) irq <= 1'b0;

      if (ev_cmd) begin
        st <= ST_RD_CMD; head <= '0;
        cod <= 1'b1; io <= 1'b0; drq <= 1'b1; bsy <= 1'b0;
      end
      if (ev_pkt_word) head <= head_inc;
      if (ev_pkt_end) begin
        st <= ST_DECIDE; drq <= 1'b0; bsy <= 1'b1;
      end
      if (ev_start) begin
        st <= st_go; head <= '0; bc_q <= bc_go;
        cod <= 1'b0; io <= (path != PATH_TO_DEV); drq <= 1'b1; bsy <= 1'b0;
      end
      if (ev_dat_in || ev_dat_out) head <= head_inc;
      if (ev_chunk) begin
        head <= '0; bc_q <= bc_next;
      end
      if (ev_done) begin
        st <= ST_STANDBY; io <= 1'b1; cod <= 1'b1; drq <= 1'b0; bsy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 6; k++) pkt_q[k] <= '0;
    end else if (ev_pkt_word) begin
      pkt_q[head[3:1]] <= dat_wdata;
    end
  end

  for (genvar k = 0; k < 6; k++) begin : g_pkt
    assign pkt_flat[16*k +: 16] = pkt_q[k];
  end

  assert_pkt_end_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_end |=> bsy && !drq && pkt_rdy);
  assert_done_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> io && cod && !drq && !bsy && irq && !pkt_rdy);
  assert_head_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_out |-> BC_W'(head) < bc_q);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_re && !irq_set |=> !irq);
  assert_stray_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdd && dat_re && !dat_we |=> head == $past(head));
  assert_bsy_drq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

endmodule

// File: rtl/pkt_pio_ctrl.sv
module pkt_pio_ctrl #(
  parameter int  BUF_BYTES  = 7168,
  parameter int  SECT_BYTES = 2352,
  parameter int  BC_W       = 16,
  localparam int AW         = $clog2(BUF_BYTES / 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_pkt,
  input  logic            dat_we,
  input  logic [15:0]     dat_wdata,
  input  logic            dat_re,
  output logic [15:0]     dat_rdata,
  input  logic            stat_re,
  input  logic            alt_re,
  output logic [7:0]      status_o,
  output logic [1:0]      reason_o,
  output logic [BC_W-1:0] bcount_o,
  output logic            irq_o,
  output logic            pkt_rdy_o,
  output logic [95:0]     pkt_o,
  input  logic            dev_go,
  input  logic [1:0]      dev_path,
  input  logic [BC_W-1:0] dev_len,
  output logic [23:0]     chunk_lba_o,
  output logic [23:0]     chunk_secs_o,
  input  logic            med_we,
  input  logic [AW-1:0]   med_addr,
  input  logic [15:0]     med_wdata,
  output logic [15:0]     med_rdata
);

  localparam int WORDS = BUF_BYTES / 2;
  localparam int SPC   = BUF_BYTES / SECT_BYTES;

  logic          sect_load, sect_adv, buf_we;
  logic [23:0]   sect_start, sect_count, sect_rem;
  logic [AW-1:0] buf_addr;
  logic          bsy, drq, cod, io;

  pkt_pio_fsm #(.BC_W(BC_W), .AW(AW), .SECT_BYTES(SECT_BYTES), .SPC(SPC)) fsm_i (
    .clk, .rst_n, .cmd_pkt, .dat_we, .dat_wdata, .dat_re, .stat_re,
    .dev_go, .dev_path, .dev_len, .sect_rem,
    .sect_load, .sect_adv, .sect_start, .sect_count,
    .buf_we, .buf_addr, .bsy, .drq, .cod, .io,
    .irq(irq_o), .pkt_rdy(pkt_rdy_o), .bcount(bcount_o), .pkt_flat(pkt_o)
  );

  pkt_pio_sect #(.SPC(SPC)) sect_i (
    .clk, .rst_n, .load(sect_load), .adv(sect_adv),
    .start(sect_start), .count(sect_count),
    .lba_o(chunk_lba_o), .secs_o(chunk_secs_o), .rem_o(sect_rem)
  );

  pkt_pio_buf #(.WORDS(WORDS), .AW(AW)) buf_i (
    .clk,
    .we_a(buf_we), .addr_a(buf_addr), .wd_a(dat_wdata), .rd_a(dat_rdata),
    .we_b(med_we), .addr_b(med_addr), .wd_b(med_wdata), .rd_b(med_rdata)
  );

  assign status_o = {bsy, 3'b000, drq, 3'b000};
  assign reason_o = {io, cod};

  assert_alt_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alt_re && !stat_re && irq_o |=> irq_o);

endmodule

// File: tb/pkt_pio_ctrl_tb.sv
module pkt_pio_ctrl_tb_top;

  localparam int SPC = 3;
  localparam int SB  = 2352;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_pkt = 0, dat_we = 0, dat_re = 0, stat_re = 0, alt_re = 0, dev_go = 0, med_we = 0;
  logic [15:0] dat_wdata = '0, med_wdata = '0, dev_len = '0;
  logic [1:0]  dev_path = '0;
  logic [11:0] med_addr = '0;
  logic [15:0] dat_rdata, med_rdata, bcount_o;
  logic [7:0]  status_o;
  logic [1:0]  reason_o;
  logic        irq_o, pkt_rdy_o;
  logic [95:0] pkt_o;
  logic [23:0] chunk_lba_o, chunk_secs_o;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  pkt_pio_ctrl dut_i (
    .clk, .rst_n, .cmd_pkt, .dat_we, .dat_wdata, .dat_re, .dat_rdata,
    .stat_re, .alt_re, .status_o, .reason_o, .bcount_o, .irq_o, .pkt_rdy_o, .pkt_o,
    .dev_go, .dev_path, .dev_len, .chunk_lba_o, .chunk_secs_o,
    .med_we, .med_addr, .med_wdata, .med_rdata
  );

  always #10 clk = ~clk;

  // path, stray, msf, a, b, c, count, len
  localparam int NV = 9;
  localparam logic [67:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 24'd0, 16'd0},
    {2'd1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 24'd0, 16'd10},
    {2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 24'd0, 16'd8},
    {2'd3, 1'b0, 1'b0, 8'h00, 8'h01, 8'h20, 24'd4, 16'd0},
    {2'd3, 1'b0, 1'b1, 8'h01, 8'h02, 8'h03, 24'd2, 16'd0},
    {2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 24'd0, 16'd4},
    {2'd2, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 24'd0, 16'd6},
    {2'd1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 24'd0, 16'd0},
    {2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 24'd0, 16'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_host(input int i);
    return 16'h1000 + 16'(i * 7);
  endfunction
  function automatic logic [15:0] pat_dev(input int i);
    return 16'hA500 ^ 16'(i * 13);
  endfunction

  task automatic clear_irq();
    stat_re = 1; tick(); stat_re = 0;
  endtask

  task automatic expect_done(input string tag);
    check({tag, " status"}, status_o, 8'h00);
    check({tag, " reason"}, reason_o, 2'b11);
    check({tag, " irq"}, irq_o, 1'b1);
    check({tag, " pkt_rdy"}, pkt_rdy_o, 1'b0);
  endtask

  task automatic run_cmd(input logic [67:0] v);
    logic [1:0]  path;
    logic        stray, msf;
    logic [7:0]  a, b, c;
    logic [23:0] cnt, lba, rem, n;
    logic [15:0] len;
    logic [15:0] w [6];
    int          nw;
    {path, stray, msf, a, b, c, cnt, len} = v;

    cmd_pkt = 1; tick(); cmd_pkt = 0;
    check("R2 status", status_o, 8'h08);
    check("R2 reason", reason_o, 2'b01);
    check("R2 irq", irq_o, 1'b1);
    clear_irq();
    check("R9 irq cleared by status read", irq_o, 1'b0);

    w[0] = {7'd0, msf, 8'hA5};
    w[1] = {b, a};
    w[2] = {8'h00, c};
    w[3] = 16'h0000;
    w[4] = {cnt[15:8], cnt[23:16]};
    w[5] = {8'h00, cnt[7:0]};
    for (int k = 0; k < 6; k++) begin
      dat_wdata = w[k]; dat_we = 1; tick(); dat_we = 0;
      if (k == 0 && stray) begin
        dat_re = 1; tick(); dat_re = 0;
      end
      if (k < 5) check("R3 drq held during packet", status_o, 8'h08);
    end
    check("R3 status after packet", status_o, 8'h80);
    check("R3 pkt_rdy", pkt_rdy_o, 1'b1);
    check("R3 packet layout", pkt_o, {w[5], w[4], w[3], w[2], w[1], w[0]});

    if (path == 2'd2) begin
      for (int i = 0; i < int'(len) / 2; i++) begin
        med_addr = 12'(i); med_wdata = pat_dev(i); med_we = 1; tick(); med_we = 0;
      end
    end

    dev_path = path; dev_len = len; dev_go = 1; tick(); dev_go = 0;

    if (path == 2'd0) begin
      expect_done("R4");
    end else if (path != 2'd3 && len == 0) begin
      expect_done("R11 zero length");
    end else if (path == 2'd3 && cnt == 0) begin
      expect_done("R11 zero count");
    end else if (path == 2'd1) begin
      check("R5 status", status_o, 8'h08);
      check("R5 reason", reason_o, 2'b00);
      check("R5 bcount", bcount_o, len);
      check("R5 irq", irq_o, 1'b1);
      clear_irq();
      if (stray) begin
        dat_re = 1; tick(); dat_re = 0;
        check("R10 stray read keeps bcount", bcount_o, len);
        check("R10 stray read keeps status", status_o, 8'h08);
      end
      nw = int'(len) / 2;
      for (int i = 0; i < nw; i++) begin
        if (i == nw - 1) check("R5 drq before last word", status_o, 8'h08);
        dat_wdata = pat_host(i); dat_we = 1; tick(); dat_we = 0;
      end
      expect_done("R5");
      for (int i = 0; i < nw; i++) begin
        med_addr = 12'(i); #1;
        check(stray ? "R10 R5 buffer word" : "R5 buffer word", med_rdata, pat_host(i));
      end
    end else if (path == 2'd2) begin
      check("R6 status", status_o, 8'h08);
      check("R6 reason", reason_o, 2'b10);
      check("R6 bcount", bcount_o, len);
      clear_irq();
      if (stray) begin
        dat_wdata = 16'hDEAD; dat_we = 1; tick(); dat_we = 0;
        check("R10 stray write keeps bcount", bcount_o, len);
        check("R10 stray write keeps reason", reason_o, 2'b10);
      end
      for (int i = 0; i < int'(len) / 2; i++) begin
        check(stray ? "R10 R6 read word" : "R6 read word", dat_rdata, pat_dev(i));
        dat_re = 1; tick(); dat_re = 0;
      end
      expect_done("R6");
    end else begin
      lba = msf ? ({16'd0, a} * 24'd4500 + {16'd0, b} * 24'd75 + {16'd0, c}) : {a, b, c};
      rem = cnt;
      check("R8 start sector", chunk_lba_o, lba);
      while (rem != 0) begin
        n = (rem > SPC) ? 24'(SPC) : rem;
        check("R7 chunk sectors", chunk_secs_o, n);
        check("R7 chunk lba", chunk_lba_o, lba);
        check("R7 bcount", bcount_o, 16'(n * SB));
        check("R7 status", status_o, 8'h08);
        check("R7 reason", reason_o, 2'b10);
        check("R7 irq per chunk", irq_o, 1'b1);
        clear_irq();
        for (int i = 0; i < int'(n) * SB / 2; i++) begin
          dat_re = 1; tick(); dat_re = 0;
        end
        lba = lba + n;
        rem = rem - n;
      end
      expect_done("R7");
    end
    clear_irq();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1 status", status_o, 8'h00);
    check("R1 reason", reason_o, 2'b00);
    check("R1 bcount", bcount_o, 16'h0);
    check("R1 irq", irq_o, 1'b0);
    check("R1 pkt_rdy", pkt_rdy_o, 1'b0);

    // stray data-register traffic while idle
    dat_wdata = 16'h7777; dat_we = 1; tick(); dat_we = 0;
    dat_re = 1; tick(); dat_re = 0;
    check("R10 idle stray status", status_o, 8'h00);
    check("R10 idle stray irq", irq_o, 1'b0);

    for (int t = 0; t < NV; t++) run_cmd(VEC[t]);

    // alternate status keeps the interrupt; set wins over clear
    cmd_pkt = 1; stat_re = 1; tick(); cmd_pkt = 0; stat_re = 0;
    check("R9 set wins over status read", irq_o, 1'b1);
    alt_re = 1; tick(); alt_re = 0;
    check("R9 alternate read keeps irq", irq_o, 1'b1);
    check("R9 alternate read keeps status", status_o, 8'h08);
    clear_irq();
    check("R9 status read clears irq", irq_o, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule